// File: doc/BRIEF.md
# Occupancy-Driven Rate and Supply Controller

This block is the local speed governor of a single network switch. It watches how full the switch's input queues are. At a programmable interval it runs a fixed-point proportional-integral update on the fullest queue's level relative to a setpoint. The result is turned into a clock-schedule index with sixteen values, where 15 is full rate and 0 is slowest, and into a choice between a high and a low supply level.

Each switch carries its own copy, and no central manager is involved. The goal is the slowest schedule that still drains the traffic arriving at the ports. A small sequencer keeps supply and rate changes in a safe order. When the rate goes up, the supply is raised first and the index follows after a settle interval. When the rate goes down, the index drops first and the supply follows later.

Top module: `rate_ctl_top`

## Requirements
- R1: After reset the rate index is 15 (fastest schedule) and the supply select is 1 (high level).
- R2: The loop update happens once every `upd_period` clock cycles, and a period of 0 acts as 1. The first update is taken on the `upd_period`-th rising edge after reset is released. Between updates the controller target does not change.
- R3: The error used by the loop is the largest occupancy among all input ports minus `setpoint`. A single busy port drives the loop as strongly as all ports being equally busy.
- R4: The integral accumulator is bounded to the range 0 to 63 and saturates there. After a long overload, one update with occupancy 0 and setpoint 8 gives a target of (55>>2)-8 = 5.
- R5: At each update the target is (accumulator>>2) + error, with the accumulator value after the update, clamped to 0..15. Reset loads the accumulator with 63.
- R6: When the target rises to 8 or above while the supply is low, the supply goes high first. The index moves to the target exactly 4 cycles later (settle 3 plus one).
- R7: When the index drops below 8 while the supply is high, the index changes first. The supply goes low exactly 3 cycles later.
- R8: An index of 8 or above never coexists with a low supply.
- R9: A change of target that needs no supply change reaches the index on the clock edge after the target changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occ_levels | input | 20 | Four 5-bit queue occupancies, port k in bits [5k+4:5k] |
| setpoint | input | 5 | Occupancy the loop regulates toward |
| upd_period | input | 4 | Cycles between loop updates (0 treated as 1) |
| freq_idx | output | 4 | Clock-schedule index, 15 = fastest |
| volt_hi | output | 1 | Supply select, 1 = high level |

## Verification
The loop is first driven with directed patterns. All ports empty makes it ramp down, which shows the drop-then-lower ordering and the clamp at 0. A single port saturated with the others empty separates a maximum-based error from a sum or average. A long overload followed by an empty input separates a bounded accumulator from one that winds up. After that, random per-port occupancies, setpoints and update periods, including 0, are compared cycle by cycle against a bench model of the loop and sequencer. This exposes any slip in update timing, arithmetic, clamping or the order of supply and index changes.

// File: rtl/rate_ctl_pkg.sv
package rate_ctl_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RAISE = 2'd1,
        SQ_LOWER = 2'd2
    } seq_state_e;
endpackage

// File: rtl/rc_tick_timer.sv
module rc_tick_timer #(
    parameter int PER_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } tmr_reg_t;

    tmr_reg_t r_q, r_d;
    logic [PER_W-1:0] per_m1;

    always_comb begin
        per_m1 = (period == '0) ? '0 : period - PER_W'(1);
        tick   = (r_q.cnt >= per_m1);
        r_d    = r_q;
        r_d.cnt = tick ? '0 : r_q.cnt + PER_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (r_q.cnt == '0));
endmodule

// File: rtl/rc_occ_max.sv
module rc_occ_max #(
    parameter int N_PORTS = 4,
    parameter int OCC_W   = 5
) (
    input  logic [N_PORTS*OCC_W-1:0] occ_flat,
    output logic [OCC_W-1:0]         occ_peak
);
    logic [OCC_W-1:0] lane [N_PORTS];

    for (genvar g = 0; g < N_PORTS; g++) begin : g_lane
        assign lane[g] = occ_flat[g*OCC_W +: OCC_W];
    end

    always_comb begin
        occ_peak = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (lane[i] > occ_peak) occ_peak = lane[i];
        end
    end
endmodule

// File: rtl/rc_pi_core.sv
module rc_pi_core #(
    parameter int OCC_W  = 5,
    parameter int IDX_W  = 4,
    parameter int KP_SHL = 0,
    parameter int KI_SHR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [OCC_W-1:0] occ_peak,
    input  logic [OCC_W-1:0] setpoint,
    output logic [IDX_W-1:0] target
);
    localparam int ACC_W = IDX_W + KI_SHR;
    localparam int SUM_W = ACC_W + OCC_W + KP_SHL + 2;
    localparam logic [ACC_W-1:0] INT_MAX = '1;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    typedef struct packed {
        logic [ACC_W-1:0] integ;
        logic [IDX_W-1:0] tgt;
    } pi_reg_t;

    pi_reg_t r_q, r_d;
    logic signed [SUM_W-1:0] err_s, acc_s, u_s;
    logic [ACC_W-1:0] integ_sat;

    always_comb begin
        err_s = $signed(SUM_W'(occ_peak)) - $signed(SUM_W'(setpoint));
        acc_s = $signed(SUM_W'(r_q.integ)) + err_s;
        if (acc_s < 0)                               integ_sat = '0;
        else if (acc_s > $signed(SUM_W'(INT_MAX)))   integ_sat = INT_MAX;
        else                                         integ_sat = acc_s[ACC_W-1:0];
        u_s = $signed(SUM_W'(integ_sat >> KI_SHR)) + (err_s <<< KP_SHL);
        r_d = r_q;
        if (tick) begin
            r_d.integ = integ_sat;
            if (u_s < 0)                                r_d.tgt = '0;
            else if (u_s > $signed(SUM_W'(IDX_MAX)))    r_d.tgt = IDX_MAX;
            else                                        r_d.tgt = u_s[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.integ <= INT_MAX;
            r_q.tgt   <= IDX_MAX;
        end else begin
            r_q <= r_d;
        end
    end

    assign target = r_q.tgt;

    p_tgt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(r_q.tgt));

    p_windup_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && r_q.integ == INT_MAX && occ_peak > setpoint) |=> (r_q.integ == INT_MAX));

    p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && r_q.integ == '0 && occ_peak < setpoint) |=> (r_q.integ == '0));
endmodule

// File: rtl/rc_vf_seq.sv
module rc_vf_seq
    import rate_ctl_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int VTH    = 8,
    parameter int SETTLE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] target,
    output logic [IDX_W-1:0] freq_idx,
    output logic             volt_hi
);
    localparam int WT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);
    localparam logic [IDX_W-1:0] VTH_L   = IDX_W'(VTH);
    localparam logic [WT_W-1:0]  WT_INIT = WT_W'(SETTLE - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] cur;
        logic             vhi;
        logic [WT_W-1:0]  wt;
    } seq_reg_t;

    seq_reg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SQ_IDLE: begin
                if (target > r_q.cur) begin
                    if (target >= VTH_L && !r_q.vhi) begin
                        r_d.vhi = 1'b1;
                        r_d.wt  = WT_INIT;
                        r_d.st  = SQ_RAISE;
                    end else begin
                        r_d.cur = target;
                    end
                end else if (target < r_q.cur) begin
                    r_d.cur = target;
                    if (target < VTH_L && r_q.vhi) begin
                        r_d.wt = WT_INIT;
                        r_d.st = SQ_LOWER;
                    end
                end
            end
            SQ_RAISE: begin
                if (r_q.wt == '0) r_d.st = SQ_IDLE;
                else              r_d.wt = r_q.wt - WT_W'(1);
            end
            SQ_LOWER: begin
                if (r_q.wt == '0) begin
                    r_d.vhi = 1'b0;
                    r_d.st  = SQ_IDLE;
                end else begin
                    r_d.wt = r_q.wt - WT_W'(1);
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= SQ_IDLE;
            r_q.cur <= '1;
            r_q.vhi <= 1'b1;
            r_q.wt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign freq_idx = r_q.cur;
    assign volt_hi  = r_q.vhi;

    p_supply_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_idx >= VTH_L) |-> volt_hi);

    p_raise_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(volt_hi) |=> $stable(freq_idx));

    p_lower_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(volt_hi) |-> (freq_idx < VTH_L) && $stable(freq_idx));
endmodule

// File: rtl/rate_ctl_top.sv
module rate_ctl_top #(
    parameter int N_PORTS = 4,
    parameter int OCC_W   = 5,
    parameter int IDX_W   = 4,
    parameter int PER_W   = 4,
    parameter int KP_SHL  = 0,
    parameter int KI_SHR  = 2,
    parameter int VTH     = 8,
    parameter int SETTLE  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PORTS*OCC_W-1:0] occ_levels,
    input  logic [OCC_W-1:0]         setpoint,
    input  logic [PER_W-1:0]         upd_period,
    output logic [IDX_W-1:0]         freq_idx,
    output logic                     volt_hi
);
    logic             tick;
    logic [OCC_W-1:0] occ_peak;
    logic [IDX_W-1:0] target;

    rc_tick_timer #(.PER_W(PER_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .period(upd_period), .tick(tick)
    );

    rc_occ_max #(.N_PORTS(N_PORTS), .OCC_W(OCC_W)) i_max (
        .occ_flat(occ_levels), .occ_peak(occ_peak)
    );

    rc_pi_core #(.OCC_W(OCC_W), .IDX_W(IDX_W), .KP_SHL(KP_SHL), .KI_SHR(KI_SHR)) i_pi (
        .clk(clk), .rst_n(rst_n), .tick(tick), .occ_peak(occ_peak),
        .setpoint(setpoint), .target(target)
    );

    rc_vf_seq #(.IDX_W(IDX_W), .VTH(VTH), .SETTLE(SETTLE)) i_seq (
        .clk(clk), .rst_n(rst_n), .target(target),
        .freq_idx(freq_idx), .volt_hi(volt_hi)
    );
endmodule

// File: tb/test_rate_ctl_top.sv
`timescale 1ns/1ps
module test_rate_ctl_top;
    localparam int NP = 4;
    localparam int OW = 5;
    localparam int SETTLE = 3;
    localparam int VTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP*OW-1:0] occ_levels = '0;
    logic [OW-1:0] setpoint = 5'd8;
    logic [3:0]    upd_period = 4'd4;
    logic [3:0]    freq_idx;
    logic          volt_hi;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rate_ctl_top i_rate_ctl_top (
        .clk(clk), .rst_n(rst_n), .occ_levels(occ_levels), .setpoint(setpoint),
        .upd_period(upd_period), .freq_idx(freq_idx), .volt_hi(volt_hi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int peak_of(input logic [NP*OW-1:0] v);
        int m = 0;
        for (int i = 0; i < NP; i++) if (int'(v[i*OW +: OW]) > m) m = int'(v[i*OW +: OW]);
        return m;
    endfunction

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // bench model state
    int m_cnt, m_integ, m_tgt, m_cur, m_vhi, m_st, m_wt;
    int t_per, t_tick, t_err, t_u;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_integ = 63; m_tgt = 15; m_cur = 15; m_vhi = 1; m_st = 0; m_wt = 0;
        end else begin
            t_per  = (upd_period == 0) ? 0 : int'(upd_period) - 1;
            t_tick = (m_cnt >= t_per) ? 1 : 0;
            case (m_st)
                0: begin
                    if (m_tgt > m_cur) begin
                        if (m_tgt >= VTH && m_vhi == 0) begin
                            m_vhi = 1; m_wt = SETTLE - 1; m_st = 1;
                        end else m_cur = m_tgt;
                    end else if (m_tgt < m_cur) begin
                        m_cur = m_tgt;
                        if (m_tgt < VTH && m_vhi == 1) begin m_st = 2; m_wt = SETTLE - 1; end
                    end
                end
                1: if (m_wt == 0) m_st = 0; else m_wt--;
                default: if (m_wt == 0) begin m_vhi = 0; m_st = 0; end else m_wt--;
            endcase
            if (t_tick == 1) begin
                t_err   = peak_of(occ_levels) - int'(setpoint);
                m_integ = clampi(m_integ + t_err, 0, 63);
                t_u     = (m_integ >> 2) + t_err;
                m_tgt   = clampi(t_u, 0, 15);
            end
            m_cnt = (t_tick == 1) ? 0 : m_cnt + 1;
        end
    end

    // per-cycle comparison and ordering measurements
    int prev_idx = 15, prev_vhi = 1;
    int t_vrise = -1, t_below = -1;
    int n_raise_gap = 0, n_lower_gap = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk(int'(freq_idx) == m_cur, "R2/R3/R5/R9 index tracks model", freq_idx, m_cur);
            chk(int'(volt_hi) == m_vhi, "R6/R7 supply tracks model", volt_hi, m_vhi);
            chk(!(freq_idx >= VTH && !volt_hi), "R8 high index needs high supply", freq_idx, VTH);
            if (volt_hi && prev_vhi == 0) t_vrise = cyc;
            if (int'(freq_idx) != prev_idx && t_vrise >= 0 && int'(freq_idx) > prev_idx) begin
                chk(cyc - t_vrise == SETTLE + 1, "R6 raise settle gap", cyc - t_vrise, SETTLE + 1);
                n_raise_gap++;
                t_vrise = -1;
            end
            if (int'(freq_idx) < VTH && prev_idx >= VTH && volt_hi) t_below = cyc;
            if (!volt_hi && prev_vhi == 1 && t_below >= 0) begin
                chk(cyc - t_below == SETTLE, "R7 lower settle gap", cyc - t_below, SETTLE);
                n_lower_gap++;
                t_below = -1;
            end
            prev_idx = int'(freq_idx);
            prev_vhi = int'(volt_hi);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        wait_cyc(3);
        chk(freq_idx == 4'd15, "R1 reset index", freq_idx, 15);
        chk(volt_hi == 1'b1, "R1 reset supply", volt_hi, 1);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(freq_idx == 4'd15 && volt_hi, "R1 held after release", freq_idx, 15);

        // ramp down: all queues empty, setpoint 8, period 4
        occ_levels = '0;
        wait_cyc(200);
        chk(freq_idx == 4'd0, "R5 clamp at slowest", freq_idx, 0);
        chk(volt_hi == 1'b0, "R7 supply lowered", volt_hi, 0);

        // one busy port only (port 2)
        occ_levels = '0;
        occ_levels[2*OW +: OW] = 5'd31;
        wait_cyc(200);
        chk(freq_idx == 4'd15, "R3 single busy port reaches fastest", freq_idx, 15);
        chk(volt_hi == 1'b1, "R6 supply raised", volt_hi, 1);
        chk(n_raise_gap >= 1, "R6 raise ordering observed", n_raise_gap, 1);
        chk(n_lower_gap >= 1, "R7 lower ordering observed", n_lower_gap, 1);

        // anti-windup: keep overload, then one update with empty queues
        wait_cyc(200);
        occ_levels = '0;
        wait_cyc(int'(upd_period) + 1);
        chk(freq_idx == 4'd5, "R4 bounded accumulator recovery", freq_idx, 5);

        // period 0 behaves as 1
        upd_period = 4'd0;
        occ_levels = {NP{5'd9}};
        wait_cyc(40);

        // random phase
        for (int it = 0; it < 3000; it++) begin
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(3, 0) == 0) occ_levels[p*OW +: OW] = OW'($urandom_range(31, 0));
            end
            if ($urandom_range(15, 0) == 0) setpoint = OW'($urandom_range(20, 2));
            if ($urandom_range(31, 0) == 0) upd_period = 4'($urandom_range(7, 0));
            wait_cyc($urandom_range(20, 1));
        end

        summary();
    end

    initial begin
        void'($urandom(32'd1337));
    end
endmodule